// File: doc/BRIEF.md
# Test-and-Set Semaphore Register

A single 16-bit shared word that up to four host functions use as a hardware lock. Every access names an operation and carries an address; the two address bits at positions 26:25 identify the requesting function, so no separate identity wire is needed. A plain read returns the word together with a test-and-set flag and leaves that flag set, so exactly one reader sees the flag clear and thereby wins the right to make one update.

The word holds a two-bit lock state, a two-bit owner, and twelve bits of free-form state (eight implementation bits and four per-function bits). Updates that change the word are only honoured from the function that won the flag; lock acquire and release follow ownership rules, and every access gets a one-cycle-later response with data, the flag as seen, and a two-bit status. Several access ports may be active in one cycle; they are resolved one after another, lowest function ID first.

Top module: `tas_semaphore`

## Requirements
- R1: After reset the word is 0 (state RESET, owner 0) and the flag is 0, so the first read returns data 0 and flag 0.
- R2: Word layout: bits [1:0] lock state with RESET=0, FREE=1, BUSY=2 (3 never appears); bits [3:2] owner ID; bits [15:4] free state.
- R3: The requester ID is address bits [26:25]; other address bits have no effect.
- R4: Opcode READ (0) returns the word and the flag as they were before the access and leaves the flag at 1; if the flag was 0, that requester becomes the flag holder. Each accepted access answers exactly one cycle later.
- R5: Opcode PEEK (1) (and reserved opcode 7) returns the word and flag and changes nothing.
- R6: Opcode CLRTAS (2) clears the flag from any requester, status OK (0).
- R7: Opcodes INIT (3), ACQUIRE (4), RELEASE (5) and SETIMPL (6) act only if the flag is 1 and the requester is the flag holder; otherwise status TASBUSY (1) and nothing changes. A successful one clears the flag.
- R8: INIT sets the lock state to FREE and keeps the other bits.
- R9: ACQUIRE from FREE sets BUSY and records the requester as owner; from RESET or BUSY it answers BADSTATE (2) and leaves word and flag unchanged.
- R10: RELEASE from the recorded owner while BUSY sets FREE; from anyone else, or while not BUSY, it answers NOTOWNER (3) and changes nothing.
- R11: SETIMPL replaces bits [15:4] with write data bits [15:4] and keeps bits [3:0].
- R12: Accesses in the same cycle are applied in order of function ID, lowest first, then port index; each sees the result of those before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PORTS | Access present, one bit per port |
| reqOp | input | 3*NUM_PORTS | Opcode per port |
| reqAddr | input | ADDR_W*NUM_PORTS | Access address per port; bits [26:25] are the ID |
| reqWdata | input | 16*NUM_PORTS | Write data per port |
| rspValid | output | NUM_PORTS | Response present, one cycle after the access |
| rspData | output | 16*NUM_PORTS | Word as seen by the access |
| rspTas | output | NUM_PORTS | Flag as seen by the access |
| rspStatus | output | 2*NUM_PORTS | OK=0, TASBUSY=1, BADSTATE=2, NOTOWNER=3 |

## Verification
Properties check on every cycle that each access is answered exactly one cycle later, that the lock state never holds the unused code, that BUSY is only entered after an acquire, that a NOTOWNER answer only follows a release, that reads leave the flag set and that peek-only cycles leave it alone. Which requester wins the flag when several read at once, the ownership sequences of init, acquire, update and release, and the exact data each access sees are only shown by the bench's scenarios, compared against a sequential model on every clock.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int WORD_W = 16;
  localparam int FID_W  = 2;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_PEEK    = 3'd1,
    OP_CLRTAS  = 3'd2,
    OP_INIT    = 3'd3,
    OP_ACQUIRE = 3'd4,
    OP_RELEASE = 3'd5,
    OP_SETIMPL = 3'd6,
    OP_RSVD    = 3'd7
  } semOp_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_TASBUSY  = 2'd1,
    ST_BADSTATE = 2'd2,
    ST_NOTOWNER = 2'd3
  } semStat_e;

  localparam logic [1:0] LOCK_RESET = 2'd0;
  localparam logic [1:0] LOCK_FREE  = 2'd1;
  localparam logic [1:0] LOCK_BUSY  = 2'd2;

  typedef struct packed {
    logic              wrValue;
    logic [WORD_W-1:0] value;
    logic              wrTas;
    logic              tas;
    logic              wrHolder;
    logic [FID_W-1:0]  holder;
  } semStrobe_t;
endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 27,
  parameter int FID_LSB   = 25
) (
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [3*NUM_PORTS-1:0]      reqOp,
  input  logic [ADDR_W*NUM_PORTS-1:0] reqAddr,
  input  logic [WORD_W*NUM_PORTS-1:0] reqWdata,
  input  logic [WORD_W-1:0]           curValue,
  input  logic                        curTas,
  input  logic [FID_W-1:0]            curHolder,
  output semStrobe_t                  strobe,
  output logic [WORD_W*NUM_PORTS-1:0] nxtData,
  output logic [NUM_PORTS-1:0]        nxtTas,
  output logic [2*NUM_PORTS-1:0]      nxtStatus
);
  localparam int NUM_FID = 1 << FID_W;

  logic [FID_W-1:0] portFid [NUM_PORTS];

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : gFid
      assign portFid[g] = reqAddr[g*ADDR_W + FID_LSB +: FID_W];
    end
  endgenerate

  always_comb begin
    logic [WORD_W-1:0] v;
    logic              t;
    logic [FID_W-1:0]  h;
    logic              touchV, touchT, touchH;
    semOp_e            op;
    semStat_e          st;
    logic [FID_W-1:0]  f2;
    v = curValue;
    t = curTas;
    h = curHolder;
    touchV = 1'b0;
    touchT = 1'b0;
    touchH = 1'b0;
    nxtData   = '0;
    nxtTas    = '0;
    nxtStatus = '0;
    for (int f = 0; f < NUM_FID; f++) begin
      f2 = FID_W'(f);
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (reqValid[p] && portFid[p] == f2) begin
          op = semOp_e'(reqOp[p*3 +: 3]);
          st = ST_OK;
          nxtData[p*WORD_W +: WORD_W] = v;
          nxtTas[p] = t;
          unique case (op)
            OP_READ: begin
              if (!t) begin
                h = f2;
                touchH = 1'b1;
              end
              t = 1'b1;
              touchT = 1'b1;
            end
            OP_CLRTAS: begin
              t = 1'b0;
              touchT = 1'b1;
            end
            OP_INIT, OP_ACQUIRE, OP_RELEASE, OP_SETIMPL: begin
              if (!(t && h == f2)) begin
                st = ST_TASBUSY;
              end else begin
                unique case (op)
                  OP_INIT: begin
                    v[1:0] = LOCK_FREE;
                  end
                  OP_ACQUIRE: begin
                    if (v[1:0] == LOCK_FREE) begin
                      v[1:0] = LOCK_BUSY;
                      v[3:2] = f2;
                    end else begin
                      st = ST_BADSTATE;
                    end
                  end
                  OP_RELEASE: begin
                    if (v[1:0] == LOCK_BUSY && v[3:2] == f2) begin
                      v[1:0] = LOCK_FREE;
                    end else begin
                      st = ST_NOTOWNER;
                    end
                  end
                  default: begin
                    v[WORD_W-1:4] = reqWdata[p*WORD_W + 4 +: WORD_W-4];
                  end
                endcase
                if (st == ST_OK) begin
                  t = 1'b0;
                  touchV = 1'b1;
                  touchT = 1'b1;
                end
              end
            end
            default: begin
            end
          endcase
          nxtStatus[p*2 +: 2] = st;
        end
      end
    end
    strobe.wrValue  = touchV;
    strobe.value    = v;
    strobe.wrTas    = touchT;
    strobe.tas      = t;
    strobe.wrHolder = touchH;
    strobe.holder   = h;
  end
endmodule

// File: rtl/sem_datapath.sv
module sem_datapath
  import sem_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  semStrobe_t                  strobe,
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [WORD_W*NUM_PORTS-1:0] nxtData,
  input  logic [NUM_PORTS-1:0]        nxtTas,
  input  logic [2*NUM_PORTS-1:0]      nxtStatus,
  output logic [WORD_W-1:0]           valueQ,
  output logic                        tasQ,
  output logic [FID_W-1:0]            holderQ,
  output logic [NUM_PORTS-1:0]        rspValid,
  output logic [WORD_W*NUM_PORTS-1:0] rspData,
  output logic [NUM_PORTS-1:0]        rspTas,
  output logic [2*NUM_PORTS-1:0]      rspStatus
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      valueQ  <= '0;
      tasQ    <= 1'b0;
      holderQ <= '0;
    end else begin
      if (strobe.wrValue)  valueQ  <= strobe.value;
      if (strobe.wrTas)    tasQ    <= strobe.tas;
      if (strobe.wrHolder) holderQ <= strobe.holder;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : gRsp
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rspValid[g]            <= 1'b0;
          rspData[g*WORD_W +: WORD_W] <= '0;
          rspTas[g]              <= 1'b0;
          rspStatus[g*2 +: 2]    <= '0;
        end else begin
          rspValid[g] <= reqValid[g];
          if (reqValid[g]) begin
            rspData[g*WORD_W +: WORD_W] <= nxtData[g*WORD_W +: WORD_W];
            rspTas[g]           <= nxtTas[g];
            rspStatus[g*2 +: 2] <= nxtStatus[g*2 +: 2];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tas_semaphore.sv
module tas_semaphore
  import sem_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 27,
  parameter int FID_LSB   = 25
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [3*NUM_PORTS-1:0]      reqOp,
  input  logic [ADDR_W*NUM_PORTS-1:0] reqAddr,
  input  logic [16*NUM_PORTS-1:0]     reqWdata,
  output logic [NUM_PORTS-1:0]        rspValid,
  output logic [16*NUM_PORTS-1:0]     rspData,
  output logic [NUM_PORTS-1:0]        rspTas,
  output logic [2*NUM_PORTS-1:0]      rspStatus
);
  semStrobe_t                  strobe;
  logic [WORD_W-1:0]           curValue;
  logic                        curTas;
  logic [FID_W-1:0]            curHolder;
  logic [WORD_W*NUM_PORTS-1:0] nxtData;
  logic [NUM_PORTS-1:0]        nxtTas;
  logic [2*NUM_PORTS-1:0]      nxtStatus;

  sem_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .FID_LSB(FID_LSB)) uCtrl (
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .curValue(curValue), .curTas(curTas), .curHolder(curHolder),
    .strobe(strobe), .nxtData(nxtData), .nxtTas(nxtTas), .nxtStatus(nxtStatus)
  );

  sem_datapath #(.NUM_PORTS(NUM_PORTS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqValid(reqValid),
    .nxtData(nxtData), .nxtTas(nxtTas), .nxtStatus(nxtStatus),
    .valueQ(curValue), .tasQ(curTas), .holderQ(curHolder),
    .rspValid(rspValid), .rspData(rspData), .rspTas(rspTas), .rspStatus(rspStatus)
  );
endmodule

// File: rtl/tas_semaphore_chk.sv
module tas_semaphore_chk
  import sem_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_PORTS-1:0]   reqValid,
  input logic [3*NUM_PORTS-1:0] reqOp,
  input logic [NUM_PORTS-1:0]   rspValid,
  input logic [2*NUM_PORTS-1:0] rspStatus,
  input logic [WORD_W-1:0]      valueQ,
  input logic                   tasQ
);
  logic anyRead, anyAcq, anyOther, anyPeekOnly;
  always_comb begin
    anyRead = 1'b0;
    anyAcq = 1'b0;
    anyOther = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (reqValid[p]) begin
        if (reqOp[p*3 +: 3] == OP_READ) anyRead = 1'b1;
        if (reqOp[p*3 +: 3] == OP_ACQUIRE) anyAcq = 1'b1;
        if (reqOp[p*3 +: 3] != OP_READ && reqOp[p*3 +: 3] != OP_PEEK &&
            reqOp[p*3 +: 3] != OP_RSVD) anyOther = 1'b1;
      end
    end
    anyPeekOnly = !anyRead && !anyOther;
  end

  // R4
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> rspValid == $past(reqValid));

  // R2
  state_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    valueQ[1:0] != 2'd3);

  // R9
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && valueQ[1:0] == LOCK_BUSY && $past(valueQ[1:0]) != LOCK_BUSY)
      |-> $past(anyAcq));

  // R4
  tas_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(anyRead) && !$past(anyOther)) |-> tasQ);

  // R5
  peek_keeps_tas_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(anyPeekOnly)) |-> tasQ == $past(tasQ));

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : gPort
      // R10
      notowner_src_chk: assert property (@(posedge clk) disable iff (!rstN)
        (rspValid[g] && rspStatus[g*2 +: 2] == ST_NOTOWNER)
          |-> $past(reqOp[g*3 +: 3]) == OP_RELEASE);
    end
  endgenerate
endmodule

bind tas_semaphore tas_semaphore_chk #(.NUM_PORTS(NUM_PORTS)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .rspValid(rspValid), .rspStatus(rspStatus), .valueQ(curValue), .tasQ(curTas)
);

// File: tb/tas_semaphore_test.sv
module tas_semaphore_test;
  localparam int NP = 2;
  localparam int AW = 27;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NP-1:0]   reqValid = '0;
  logic [3*NP-1:0] reqOp = '0;
  logic [AW*NP-1:0] reqAddr = '0;
  logic [16*NP-1:0] reqWdata = '0;
  logic [NP-1:0]   rspValid;
  logic [16*NP-1:0] rspData;
  logic [NP-1:0]   rspTas;
  logic [2*NP-1:0] rspStatus;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural model state
  int mVal = 0, mTas = 0, mHold = 0;
  int eValid [NP], eData [NP], eTas [NP], eStat [NP], eOp [NP];

  tas_semaphore #(.NUM_PORTS(NP), .ADDR_W(AW), .FID_LSB(25)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData), .rspTas(rspTas),
    .rspStatus(rspStatus)
  );

  always #5 clk = ~clk;

  function automatic string tagOf(int op);
    case (op)
      0: return "R4";
      1, 7: return "R5";
      2: return "R6";
      3: return "R8";
      4: return "R9";
      5: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setReq(int p, int op, int fid, int wd);
    reqValid[p] = 1'b1;
    reqOp[p*3 +: 3] = 3'(op);
    reqAddr[p*AW +: AW] = {2'(fid), 25'($urandom)};
    reqWdata[p*16 +: 16] = 16'(wd);
  endtask

  // model: apply requests in ID order then port order
  task automatic model();
    for (int p = 0; p < NP; p++) eValid[p] = reqValid[p];
    for (int f = 0; f < 4; f++) begin
      for (int p = 0; p < NP; p++) begin
        if (reqValid[p] && int'(reqAddr[p*AW + 25 +: 2]) == f) begin
          int op;
          op = int'(reqOp[p*3 +: 3]);
          eOp[p] = op; eData[p] = mVal; eTas[p] = mTas; eStat[p] = 0;
          if (op == 0) begin
            if (mTas == 0) mHold = f;
            mTas = 1;
          end else if (op == 2) begin
            mTas = 0;
          end else if (op >= 3 && op <= 6) begin
            if (!(mTas == 1 && mHold == f)) eStat[p] = 1;
            else if (op == 3) mVal = (mVal & 'hFFFC) | 1;
            else if (op == 4) begin
              if ((mVal & 3) == 1) mVal = (mVal & 'hFFF0) | (f << 2) | 2;
              else eStat[p] = 2;
            end else if (op == 5) begin
              if ((mVal & 3) == 2 && ((mVal >> 2) & 3) == f) mVal = (mVal & 'hFFFC) | 1;
              else eStat[p] = 3;
            end else begin
              mVal = (int'(reqWdata[p*16 +: 16]) & 'hFFF0) | (mVal & 'hF);
            end
            if (eStat[p] == 0) mTas = 0;
          end
        end
      end
    end
  endtask

  task automatic step();
    model();
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      check("R4 rspValid", int'(rspValid[p]), eValid[p]);
      if (eValid[p] != 0) begin
        check({tagOf(eOp[p]), " data"}, int'(rspData[p*16 +: 16]), eData[p]);
        check({tagOf(eOp[p]), " tas"}, int'(rspTas[p]), eTas[p]);
        check({tagOf(eOp[p]), " R7 status"}, int'(rspStatus[p*2 +: 2]), eStat[p]);
      end
    end
    reqValid = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state seen by first read (R3: ID from addr bits)
    setReq(0, 0, 2, 0); step();
    check("R1 first read", int'(rspData[15:0]), 0);
    setReq(0, 2, 0, 0); step();                        // R6
    setReq(1, 4, 1, 0); step();                        // R7 no flag
    setReq(0, 0, 1, 0); step();
    setReq(0, 4, 1, 0); step();                        // R9 from RESET
    check("R9 bad state", int'(rspStatus[1:0]), 2);
    setReq(1, 3, 1, 0); step();                        // R8 init
    setReq(0, 0, 1, 0); step();
    setReq(0, 4, 1, 0); step();                        // R9 acquire
    setReq(1, 0, 2, 0); step();
    check("R2 busy owner1", int'(rspData[16 +: 4]), 4'b0110);
    setReq(1, 5, 2, 0); step();                        // R10 not owner
    check("R10 not owner", int'(rspStatus[3:2]), 3);
    setReq(0, 2, 3, 0); step();
    setReq(0, 1, 0, 0); setReq(1, 7, 2, 0); step();    // R5
    setReq(0, 0, 1, 0); step();
    setReq(1, 6, 1, 'hABC5); step();                   // R11
    setReq(0, 1, 0, 0); step();
    check("R11 impl bits", int'(rspData[15:0]), 'hABC6);
    // R12: same-cycle reads, lower ID on port 1 wins
    setReq(0, 0, 3, 0); setReq(1, 0, 1, 0); step();
    check("R12 winner port1", int'(rspTas[1]), 0);
    check("R12 loser port0", int'(rspTas[0]), 1);
    setReq(0, 5, 1, 0); step();                        // R10 owner release
    for (int i = 0; i < 400; i++) begin
      for (int p = 0; p < NP; p++)
        if ($urandom_range(0, 3) != 0)
          setReq(p, $urandom_range(0, 7), $urandom_range(0, 3), $urandom);
      step();
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule